// File: doc/BRIEF.md
# Asynchronous SRAM Read Timing Engine

This block runs single asynchronous read cycles on a static memory device. A command source raises a read request with an address. When the engine is free, it drives chip select and the address on the memory pins. It asserts output enable after a programmable delay and holds every control for a programmable number of memory clock cycles. It samples the device's data on the falling edge of the memory clock in the last cycle of the access. The captured word is then pushed into a small read FIFO, and the requesting side drains that FIFO.

The cycle length and the output-enable delay are runtime inputs, and the engine latches both when it accepts a request. The engine runs only when the configuration selects asynchronous reads: synchronous mode off and a burst length of zero. A busy flag tells the command side when a request would be ignored.

Top module: `sram_async_rd`

## Requirements
- R1: After a synchronous reset, mem_cs_n and mem_oe_n are 1, busy is 0 and fifo_empty is 1.
- R2: A request is accepted at a clock edge where req_valid is 1 and busy is 0. From that edge, mem_cs_n is 0 and mem_addr holds the request address for T cycles. T is cfg_cycle_len, and a value of 0 counts as 1.
- R3: Number the cycles of an access 0 to T-1, with cycle 0 the first cycle with chip select low. mem_oe_n goes low in cycle D, where D is cfg_oe_delay, and stays low until the end of the access. It rises at the same edge as mem_cs_n, and it is never low while mem_cs_n is high.
- R4: When D is greater than or equal to T, mem_oe_n is low only in cycle T-1.
- R5: mem_rdata is captured at the falling clock edge inside cycle T-1. The word is readable on fifo_rdata once it reaches the head of the FIFO.
- R6: Each accepted request pushes exactly one word into the FIFO, at the edge that ends the access. Words leave in request order. A pop while fifo_empty is 1 has no effect.
- R7: busy is 1 while an access is in progress or while the FIFO holds DEPTH words. A request made while busy is 1 is ignored.
- R8: A request is ignored unless cfg_rd_sync is 0 and cfg_rd_burst is 000.
- R9: cfg_cycle_len and cfg_oe_delay are sampled when a request is accepted. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; data is sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cycle_len | input | 4 | Read cycle length in clock cycles |
| cfg_oe_delay | input | 3 | Chip select to output enable delay in cycles |
| cfg_rd_sync | input | 1 | Synchronous read mode; must be 0 for this engine |
| cfg_rd_burst | input | 3 | Read burst length; must be 000 for this engine |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Read address |
| busy | output | 1 | Access in progress or FIFO full |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_rdata | input | DATA_W | Data returned by the memory |
| fifo_pop | input | 1 | Removes the head word of the read FIFO |
| fifo_rdata | output | DATA_W | Head word of the read FIFO |
| fifo_empty | output | 1 | Read FIFO holds no word |

## Verification
The bench drives mem_rdata with a value that changes every cycle. A word captured one cycle too early or too late therefore shows up as a wrong FIFO value. A fixed pattern of length three and delay one checks the basic pin sequence. A run with the delay at or beyond the cycle length, and one with a length of zero, checks that the delay is clamped to the last cycle. A run with no pops fills the FIFO and shows busy caused by a full FIFO, separate from busy caused by an access in progress. The later drain checks the word order. Other runs set the illegal mode bits or change the configuration on every cycle, which shows that requests are gated by the mode and that the timing is latched per access.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;
  localparam int CYC_W   = 4;
  localparam int DLY_W   = 3;
  localparam int BURST_W = 3;

  typedef logic [CYC_W-1:0] cyc_t;
  typedef logic [DLY_W-1:0] dly_t;

  // index of the final cycle of an access; a length of zero behaves as one
  function automatic cyc_t last_index(input cyc_t len);
    return (len == '0) ? '0 : cyc_t'(len - cyc_t'(1));
  endfunction

  // output-enable start cycle, clamped so it is asserted at least once
  function automatic cyc_t oe_start(input dly_t dly, input cyc_t last);
    cyc_t d;
    d = cyc_t'(dly);
    return (d > last) ? last : d;
  endfunction
endpackage

// File: rtl/sram_rd_timer.sv
module sram_rd_timer
  import sram_rd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  cyc_t              cfg_len,
  input  dly_t              cfg_dly,
  output logic              active,
  output logic              final_cyc,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr
);
  logic              active_q;
  cyc_t              cnt_q;
  cyc_t              last_q;
  cyc_t              oes_q;
  logic              cs_n_q;
  logic              oe_n_q;
  logic [ADDR_W-1:0] addr_q;
  cyc_t              cnt_nx;
  cyc_t              new_last;
  cyc_t              new_oes;

  always_comb begin
    cnt_nx   = cyc_t'(cnt_q + cyc_t'(1));
    new_last = last_index(cfg_len);
    new_oes  = oe_start(cfg_dly, new_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
      oes_q    <= '0;
      cs_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      addr_q   <= '0;
    end else if (active_q) begin
      if (cnt_q == last_q) begin
        active_q <= 1'b0;
        cs_n_q   <= 1'b1;
        oe_n_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_nx;
        if (cnt_nx >= oes_q) oe_n_q <= 1'b0;
      end
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      last_q   <= new_last;
      oes_q    <= new_oes;
      cs_n_q   <= 1'b0;
      oe_n_q   <= (new_oes != '0);
      addr_q   <= start_addr;
    end
  end

  assign active    = active_q;
  assign final_cyc = active_q && (cnt_q == last_q);
  assign mem_cs_n  = cs_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_addr  = addr_q;

  // R2: address is held for the whole access
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_q && $past(!cs_n_q)) |-> $stable(addr_q));
  // R3: output enable only inside chip select
  p_oe_inside_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> oe_n_q);
  // R3: once enabled, output enable stays low until it rises with chip select
  p_oe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_q && !cs_n_q) |=> (oe_n_q == cs_n_q));
endmodule

// File: rtl/sram_rd_fifo.sv
module sram_rd_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr;
  logic [PW-1:0]     rd_ptr;
  logic [CW-1:0]     count;
  logic              do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + PW'(1));
  endfunction

  assign do_pop = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      if (push && !do_pop)      count <= CW'(count + CW'(1));
      else if (!push && do_pop) count <= CW'(count - CW'(1));
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R6: a word is never written into a full FIFO
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
endmodule

// File: rtl/sram_async_rd.sv
module sram_async_rd
  import sram_rd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CYC_W-1:0]   cfg_cycle_len,
  input  logic [DLY_W-1:0]   cfg_oe_delay,
  input  logic               cfg_rd_sync,
  input  logic [BURST_W-1:0] cfg_rd_burst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               busy,
  output logic               mem_cs_n,
  output logic               mem_oe_n,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               fifo_pop,
  output logic [DATA_W-1:0]  fifo_rdata,
  output logic               fifo_empty
);
  logic              active;
  logic              final_cyc;
  logic              fifo_full;
  logic              mode_ok;
  logic              start;
  logic [DATA_W-1:0] cap_q;

  assign mode_ok = !cfg_rd_sync && (cfg_rd_burst == '0);
  assign busy    = active || fifo_full;
  assign start   = req_valid && !busy && mode_ok;

  sram_rd_timer #(.ADDR_W(ADDR_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (req_addr),
    .cfg_len    (cfg_cycle_len),
    .cfg_dly    (cfg_oe_delay),
    .active     (active),
    .final_cyc  (final_cyc),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_addr   (mem_addr)
  );

  // capture on the falling edge inside the last access cycle
  always_ff @(negedge clk) begin
    if (final_cyc) cap_q <= mem_rdata;
  end

  sram_rd_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (final_cyc),
    .wdata (cap_q),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  // R6: the push coincides with the end of the access
  p_push_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    final_cyc |=> mem_cs_n);
  // R7: an access never starts from a busy state
  p_start_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cs_n) |-> !$past(busy));
  // R8: an access only starts in asynchronous single mode
  p_mode_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cs_n) |-> $past(mode_ok));
endmodule

// File: tb/test_sram_async_rd.sv
module test_sram_async_rd;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    cfg_cycle_len = '0;
  logic [2:0]    cfg_oe_delay = '0;
  logic          cfg_rd_sync = 1'b0;
  logic [2:0]    cfg_rd_burst = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy;
  logic          mem_cs_n;
  logic          mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          fifo_pop = 1'b0;
  logic [DW-1:0] fifo_rdata;
  logic          fifo_empty;

  int checks = 0;
  int errors = 0;
  int tick = 0;
  bit done = 1'b0;

  // reference model state
  bit            m_act = 1'b0;
  int            m_cyc = 0;
  int            m_last = 0;
  int            m_oes = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_q[$];

  always #5 clk = ~clk;

  sram_async_rd #(.ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(DEPTH)) i_sram_async_rd (
    .clk(clk), .rst(rst), .cfg_cycle_len(cfg_cycle_len), .cfg_oe_delay(cfg_oe_delay),
    .cfg_rd_sync(cfg_rd_sync), .cfg_rd_burst(cfg_rd_burst), .req_valid(req_valid),
    .req_addr(req_addr), .busy(busy), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .fifo_pop(fifo_pop),
    .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at t=%0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // advance the model by one clock edge using the inputs held before it
  task automatic model_step();
    bit busy_pre;
    bit legal;
    busy_pre = m_act || (m_q.size() == DEPTH);
    legal = !cfg_rd_sync && (cfg_rd_burst == 3'b000);
    if (fifo_pop && m_q.size() > 0) void'(m_q.pop_front());
    if (m_act) begin
      if (m_cyc == m_last) begin
        m_act = 1'b0;
        m_q.push_back(mem_rdata);
      end else m_cyc++;
    end else if (req_valid && !busy_pre && legal) begin
      m_act  = 1'b1;
      m_cyc  = 0;
      m_last = (cfg_cycle_len == 0) ? 0 : int'(cfg_cycle_len) - 1;
      m_oes  = (int'(cfg_oe_delay) > m_last) ? m_last : int'(cfg_oe_delay);
      m_addr = req_addr;
    end
  endtask

  task automatic compare(input string ph);
    chk({"R2 cs_n [", ph, "]"}, 32'(mem_cs_n), 32'(!m_act));
    if (m_act) chk({"R2 addr [", ph, "]"}, 32'(mem_addr), 32'(m_addr));
    chk({"R3 R4 oe_n [", ph, "]"}, 32'(mem_oe_n), 32'(!(m_act && m_cyc >= m_oes)));
    chk({"R7 busy [", ph, "]"}, 32'(busy), 32'(m_act || m_q.size() == DEPTH));
    chk({"R6 empty [", ph, "]"}, 32'(fifo_empty), 32'(m_q.size() == 0));
    if (m_q.size() > 0) chk({"R5 data [", ph, "]"}, 32'(fifo_rdata), 32'(m_q[0]));
  endtask

  // apply inputs just after an edge, then step and compare after the next edge
  task automatic cycle(input string ph, input bit rv, input logic [AW-1:0] a,
                       input logic [3:0] len, input logic [2:0] dly,
                       input bit sync, input logic [2:0] bl, input bit pop);
    req_valid = rv;
    req_addr = a;
    cfg_cycle_len = len;
    cfg_oe_delay = dly;
    cfg_rd_sync = sync;
    cfg_rd_burst = bl;
    fifo_pop = pop;
    tick++;
    mem_rdata = DW'(16'h5a00 + tick * 7);
    @(posedge clk);
    #1;
    model_step();
    compare(ph);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 cs_n", 32'(mem_cs_n), 32'd1);
    chk("R1 oe_n", 32'(mem_oe_n), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 empty", 32'(fifo_empty), 32'd1);

    // R2 R3 R5: fixed length 3, delay 1
    for (int i = 0; i < 40; i++)
      cycle("R2 R3 R5 basic", ($urandom % 2) == 0, AW'(i * 37), 4'd3, 3'd1, 1'b0, 3'b000, 1'b1);
    // R4: delay at or beyond the cycle length, and zero length
    for (int i = 0; i < 30; i++)
      cycle("R4 clamp", 1'b1, AW'(i * 11), 4'd2, 3'd5, 1'b0, 3'b000, 1'b1);
    for (int i = 0; i < 20; i++)
      cycle("R4 zero len", 1'b1, AW'(i * 5), 4'd0, 3'd0, 1'b0, 3'b000, 1'b1);
    // R7: fill the FIFO without pops, then R6 drain in order (pops past empty too)
    for (int i = 0; i < 30; i++)
      cycle("R7 full", 1'b1, AW'(i + 100), 4'd1, 3'd0, 1'b0, 3'b000, 1'b0);
    for (int i = 0; i < 10; i++)
      cycle("R6 drain", 1'b0, '0, 4'd1, 3'd0, 1'b0, 3'b000, 1'b1);
    // R8: illegal mode settings ignore requests
    for (int i = 0; i < 20; i++)
      cycle("R8 sync", 1'b1, AW'(i), 4'd3, 3'd1, 1'b1, 3'b000, 1'b1);
    for (int i = 0; i < 20; i++)
      cycle("R8 burst", 1'b1, AW'(i), 4'd3, 3'd1, 1'b0, 3'b011, 1'b1);
    // R9: configuration changes on every cycle
    for (int i = 0; i < 200; i++)
      cycle("R9 cfg", ($urandom % 3) != 0, AW'($urandom), 4'($urandom), 3'($urandom),
            1'b0, 3'b000, ($urandom % 4) != 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule